// File: doc/BRIEF.md
# Three-Tap Pipelined Transposed FIR Filter

This block is a three-tap finite impulse response filter with fixed signed coefficients A, B and C. It computes y(n) = A·x(n) + B·x(n-1) + C·x(n-2) at full precision. The upstream logic offers one signed sample per clock, qualified by a valid flag. The block answers with one filtered result per accepted sample, a fixed number of cycles later, and a valid flag that stays aligned with that result.

The adder chain uses the transposed arrangement. Every coefficient multiplies the newest sample, and the partial sums move through registers toward the output, so only one adder sits after each product. Each constant multiplier is split into two register stages. The first stage forms the product with the unsigned low half of the coefficient. The second stage adds the product with the signed high half, shifted left by the width of the low half. The registers between the stages cut every path from the input to the output in the same direction, so they do not change the function, only the latency.

A cycle whose valid flag is low is a bubble. It carries no sample, leaves the tap history untouched and does not change the output. A synchronous reset empties the whole pipe and the tap history.

Top module: `fir_xpose_pipe`

## Requirements
- R1: For every accepted sample, `outSample` equals A·x(n) + B·x(n-1) + C·x(n-2) as a signed two's-complement value of width DW+CW+2. Here x(n-1) and x(n-2) are the two previously accepted samples, and both count as zero when fewer samples have been accepted since reset.
- R2: `outValid` is high in a cycle exactly when `inValid` was high three rising edges earlier, with no reset in between. The result of a sample accepted at edge k appears after edge k+2.
- R3: Cycles with `inValid` low do not advance the tap history. Samples separated by any number of bubbles combine as if they had arrived back to back.
- R4: While `outValid` is low, `outSample` keeps the value it had in the previous cycle.
- R5: While `rst` is high at a rising edge, `outValid` and `outSample` read zero after that edge. The tap history and all in-flight samples are dropped, and inputs presented during reset are ignored.
- R6: Coefficients are signed CW-bit values that are split internally into an unsigned low half and a signed high half. The result is exact for every coefficient value, including the most negative one, -1, and values whose low half is all ones.
- R7: The block accepts a valid sample on every cycle without stalls and delivers one result per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks `inSample` as a sample to accept |
| inSample | input | DW | Signed input sample |
| outValid | output | 1 | Marks `outSample` as a new filter result |
| outSample | output | DW+CW+2 | Signed filter result |

## Verification
Two things often happen in the same cycle. A newer sample enters the first multiplier stage while an older one updates the transposed sum chain, and a bubble can enter the pipe while an earlier valid result is still leaving it. Random valid patterns, mixed with long back-to-back runs and a reset in the middle of a stream, create every overlap of these events. Each cycle, the bench compares both output ports with an arithmetic model that has its own three-deep delay line. Two instances with different coefficient sets are swept over every 8-bit sample value.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // register stages from input to output: two multiplier halves, then the sum chain
  localparam int LATENCY = 3;

  typedef struct packed {
    logic ldMul1;   // first multiplier half captures a new sample
    logic ldMul2;   // second multiplier half completes the product
    logic ldSum;    // transposed sum chain and output register advance
  } firStrobe_t;
endpackage

// File: rtl/fir_ctl.sv
module fir_ctl
  import fir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output firStrobe_t strobe,
  output logic       outValid
);
  logic [LATENCY-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[LATENCY-2:0], inValid};
  end

  always_comb begin
    strobe.ldMul1 = inValid;
    strobe.ldMul2 = vPipe[0];
    strobe.ldSum  = vPipe[1];
  end

  assign outValid = vPipe[LATENCY-1];
endmodule

// File: rtl/fir_split_mult.sv
module fir_split_mult #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int COEF = 0,
  parameter int PW   = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld1,
  input  logic                 ld2,
  input  logic signed [DW-1:0] x,
  output logic signed [PW-1:0] prod
);
  localparam int LH = CW / 2;
  localparam int HW = CW - LH;
  localparam logic [CW-1:0] CBITS = COEF[CW-1:0];
  localparam logic signed [PW-1:0] LO_EXT = {{(PW-LH){1'b0}}, CBITS[LH-1:0]};
  localparam logic signed [PW-1:0] HI_EXT = {{(PW-HW){CBITS[CW-1]}}, CBITS[CW-1:LH]};

  logic signed [PW-1:0] xExt, loProd, xHold, loPart, hiProd;

  assign xExt   = {{(PW-DW){x[DW-1]}}, x};
  assign loProd = xExt * LO_EXT;

  always_ff @(posedge clk) begin
    if (rst) begin
      xHold  <= '0;
      loPart <= '0;
    end else if (ld1) begin
      xHold  <= xExt;
      loPart <= loProd;
    end
  end

  assign hiProd = (xHold * HI_EXT) <<< LH;

  always_ff @(posedge clk) begin
    if (rst)      prod <= '0;
    else if (ld2) prod <= hiProd + loPart;
  end
endmodule

// File: rtl/fir_dp.sv
module fir_dp
  import fir_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int COEF_A = 23,
  parameter int COEF_B = -77,
  parameter int COEF_C = 109,
  parameter int OW     = DW + CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  firStrobe_t           strobe,
  input  logic signed [DW-1:0] inSample,
  output logic signed [OW-1:0] yOut
);
  localparam int NTAP = 3;
  localparam int PW   = DW + CW;

  logic signed [PW-1:0] prodArr [NTAP];
  logic signed [OW-1:0] prodExt [NTAP];
  logic signed [OW-1:0] partSum [NTAP];

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int CF = (g == 0) ? COEF_A : ((g == 1) ? COEF_B : COEF_C);
    fir_split_mult #(.DW(DW), .CW(CW), .COEF(CF), .PW(PW)) u_mult (
      .clk (clk),
      .rst (rst),
      .ld1 (strobe.ldMul1),
      .ld2 (strobe.ldMul2),
      .x   (inSample),
      .prod(prodArr[g])
    );
    assign prodExt[g] = {{(OW-PW){prodArr[g][PW-1]}}, prodArr[g]};

    if (g == 0) begin : g_out
      always_ff @(posedge clk) begin
        if (rst)               partSum[g] <= '0;
        else if (strobe.ldSum) partSum[g] <= prodExt[g] + partSum[g+1];
      end
    end else if (g == NTAP-1) begin : g_last
      always_ff @(posedge clk) begin
        if (rst)               partSum[g] <= '0;
        else if (strobe.ldSum) partSum[g] <= prodExt[g];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)               partSum[g] <= '0;
        else if (strobe.ldSum) partSum[g] <= prodExt[g] + partSum[g+1];
      end
    end
  end

  assign yOut = partSum[0];
endmodule

// File: rtl/fir_xpose_pipe.sv
module fir_xpose_pipe
  import fir_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int COEF_A = 23,
  parameter int COEF_B = -77,
  parameter int COEF_C = 109,
  localparam int OW    = DW + CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inSample,
  output logic                 outValid,
  output logic signed [OW-1:0] outSample
);
  firStrobe_t strobe;

  fir_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  fir_dp #(
    .DW(DW), .CW(CW), .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C), .OW(OW)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inSample(inSample),
    .yOut    (outSample)
  );
endmodule

// File: rtl/fir_chk.sv
module fir_chk #(
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic          outValid,
  input logic [OW-1:0] outSample
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##3 outValid);                                   // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3));                             // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outSample));                           // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && outSample == '0));                     // R5
endmodule

bind fir_xpose_pipe fir_chk #(.OW(OW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outSample(outSample)
);

// File: tb/test_fir_xpose_pipe.sv
module test_fir_xpose_pipe;
  localparam int NDUT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [7:0] inSample = '0;
  logic outValid [NDUT];
  logic signed [17:0] outSample [NDUT];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int coef [NDUT][3] = '{'{23, -77, 109}, '{-128, 127, -1}};
  int hist [NDUT][2];
  int pe [NDUT][3];
  bit pv [3];
  int lastExp [NDUT];

  always #10 clk = ~clk;   // 50 MHz

  fir_xpose_pipe #(.DW(8), .CW(8), .COEF_A(23), .COEF_B(-77), .COEF_C(109)) i_fir_xpose_pipe (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid[0]), .outSample(outSample[0]));

  fir_xpose_pipe #(.DW(8), .CW(8), .COEF_A(-128), .COEF_B(127), .COEF_C(-1)) i_fir_xpose_pipe_ext (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid[1]), .outSample(outSample[1]));

  task automatic clearModel();
    for (int d = 0; d < NDUT; d++) begin
      hist[d][0] = 0; hist[d][1] = 0; lastExp[d] = 0;
      for (int s = 0; s < 3; s++) pe[d][s] = 0;
    end
    for (int s = 0; s < 3; s++) pv[s] = 0;
  endtask

  task automatic checkOut(input string tag);
    for (int d = 0; d < NDUT; d++) begin
      int act;
      int exp;
      act = outSample[d];
      checks++;
      if (outValid[d] !== pv[2]) begin
        errors++;
        $display("FAIL R2 dut%0d outValid actual %0b expected %0b", d, outValid[d], pv[2]);
      end
      exp = pv[2] ? pe[d][2] : lastExp[d];
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL %s dut%0d outSample actual %0d expected %0d", pv[2] ? tag : "R4", d, act, exp);
      end
      if (pv[2]) lastExp[d] = pe[d][2];
    end
  endtask

  // one clock: check what the outputs hold now, then present the next input
  task automatic step(input bit v, input int x, input string tag);
    @(negedge clk);
    checkOut(tag);
    rst = 1'b0;
    inValid = v;
    inSample = 8'(x);
    pv[2] = pv[1]; pv[1] = pv[0]; pv[0] = v;
    for (int d = 0; d < NDUT; d++) begin
      pe[d][2] = pe[d][1]; pe[d][1] = pe[d][0];
      if (v) begin
        pe[d][0] = coef[d][0] * x + coef[d][1] * hist[d][0] + coef[d][2] * hist[d][1];
        hist[d][1] = hist[d][0];
        hist[d][0] = x;
      end else pe[d][0] = 0;
    end
  endtask

  task automatic resetFor(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        for (int d = 0; d < NDUT; d++) begin
          checks++;
          if (outValid[d] !== 1'b0 || outSample[d] !== '0) begin
            errors++;
            $display("FAIL R5 dut%0d in reset actual v=%0b y=%0d expected v=0 y=0",
                     d, outValid[d], outSample[d]);
          end
        end
      end
      rst = 1'b1;
      inValid = 1'b1;   // ignored during reset (R5)
      inSample = 8'($urandom);
    end
    clearModel();
  endtask

  initial begin
    clearModel();
    resetFor(3);
    // R5: zero history right after reset, then R7/R6/R1 back-to-back sweep of every value
    step(1, 100, "R5");
    step(1, -3, "R5");
    for (int x = -128; x < 128; x++) step(1, x, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, "R4");
    // R1 extremes back to back
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 127 : -128, "R1");
    step(1, -128, "R1"); step(1, -128, "R1"); step(1, -128, "R1");
    // R3/R4: random bubbles between samples
    for (int i = 0; i < 800; i++) step(bit'($urandom_range(0, 1)), $urandom_range(0, 255) - 128, "R3");
    // long gaps between valid samples (R3)
    for (int i = 0; i < 10; i++) begin
      step(1, $urandom_range(0, 255) - 128, "R3");
      for (int j = 0; j < i; j++) step(0, 55, "R3");
    end
    // R5: reset in the middle of a stream drops history and in-flight data
    step(1, 90, "R1"); step(1, -90, "R1");
    resetFor(2);
    step(1, 7, "R5"); step(0, 0, "R5"); step(1, -1, "R5"); step(1, 2, "R5");
    for (int i = 0; i < 6; i++) step(0, 0, "R4");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule